// File: doc/BRIEF.md
# Modem Turn-On Training Sequencer

This transmit-side controller produces the synchronizing preamble a differential phase modulator sends between the moment the terminal raises request-to-send and the moment the modem reports ready-for-sending. For each symbol, marked by a one-cycle symbol strobe, it issues a phase-change command in units of 45 degrees and a carrier-enable. It walks through five segments: unmodulated carrier, silence, continuous phase reversals, an equalizer conditioning pattern, and a short run of scrambled mark data. Ready-for-sending is raised after the last segment.

The first turn-on after the connection comes up uses a long preamble, which gives the far receiver time to converge its equalizer from scratch. Every later turn-around uses a short preamble. The equalizer pattern is taken from a seven-stage pseudo-random generator that is fed with ones. By default one bit in three is used; in an alternate mode one bit in two is used. When request-to-send drops, the block enters a turn-off window of fixed length. A new request that arrives during this window waits until the window ends.

Top module: `preamble_sequencer`

## Requirements
- R1: While `rst` is high and at the first sample after it goes low, `carrier_o`, `rfs_o` and `phase_o` are all 0 and the block is idle.
- R2: All state changes and output updates happen only on clock edges where `sym_stb` is 1. A preamble starts only at a strobe where both `rts_i` and `conn_i` are 1. Outputs always reflect the symbol issued at the most recent strobe.
- R3: The long preamble is used for the first start after a rising edge of `conn_i`. This includes a start at the first strobe after the rising edge when `rts_i` is already 1. Every other start uses the short preamble.
- R4: Segment one lasts CARR_LEN symbols with carrier on and phase code 0. Segment two lasts QUIET_LEN symbols with carrier off and phase code 0.
- R5: Segment three sends phase code 4 (180 degrees) with carrier on, for 14 symbols in the short preamble or 50 in the long one.
- R6: Segment four lasts 58 (short) or 1074 (long) symbols. The generator produces g = 1 XOR s6 XOR s7 and shifts g into s1, where sk is the bit from k steps back. Its stages s1..s7 are loaded with 0,0,1,1,1,1,0 when the segment starts. In default mode the generator advances three bits per symbol, and the first of those bits picks the code: bit 0 gives code 0, bit 1 gives code 4. The codes start 0,4,4,4,4,4,0.
- R7: With alternate mode selected, segment four advances two bits per symbol, and the codes start 0,4,0,4,4,0,4.
- R8: Segment five lasts 8 symbols. The generator continues from where it was, three bits per symbol at the high rate and two at the low rate. The group (b1 first in time) maps to codes as follows. High rate: 001→0, 000→1, 010→2, 011→3, 111→4, 110→5, 100→6, 101→7. Low rate: 00→0, 01→2, 11→4, 10→6.
- R9: The strobe after the last symbol of segment five sets `rfs_o` to 1. `rfs_o` stays at 1, with carrier on and code 0, while `rts_i` remains 1.
- R10: At a strobe where `rts_i` is 0 during any preamble segment or during data, the block clears `rfs_o` and enters a turn-off window. The window lasts OFF_LEN symbols with carrier on and code 0. After it the block goes idle, with carrier off.
- R11: A request that rises during the turn-off window has no effect until the window ends. If `rts_i` and `conn_i` are both 1 at the window's last strobe, the short preamble begins at the next symbol.
- R12: The rate and pattern-mode inputs are captured at the strobe that starts a preamble. Changing them later in that preamble has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | One-cycle pulse per symbol interval |
| rts_i | input | 1 | Request-to-send from the terminal |
| conn_i | input | 1 | Connection established |
| rate_hi_i | input | 1 | 1 = three bits per symbol, 0 = two bits per symbol |
| alt_pat_i | input | 1 | 1 = take every second generator bit in segment four |
| phase_o | output | 3 | Phase change for the current symbol, in 45-degree units |
| carrier_o | output | 1 | Carrier enable |
| rfs_o | output | 1 | Ready-for-sending |

## Verification
The bench checks every symbol of each preamble against an independent model of the generator and the encoding tables. A segment length that is off by one shifts everything after it, so a wrong length shows up immediately. It tests the long/short choice both when the request is already high as the connection comes up and on a later turn-around. A design that chose by request edge alone would send a short preamble where a long one is due. It raises a request during the turn-off window; a design that did not defer it would start the carrier segment early. It aborts a preamble in the middle of segment four, and toggles the rate and mode inputs after a start. A design that did not capture them at the start would switch bit grouping partway through the sequence.

// File: rtl/preamble_pkg.sv
package preamble_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CARR  = 3'd1,
    ST_QUIET = 3'd2,
    ST_REV   = 3'd3,
    ST_EQ    = 3'd4,
    ST_SYNC  = 3'd5,
    ST_DATA  = 3'd6,
    ST_OFF   = 3'd7
  } pa_state_e;

  // b[0] is earliest in time; result in 45-degree units
  function automatic logic [2:0] map_bits(input logic hi, input logic [2:0] b);
    logic [2:0] code;
    if (hi) begin
      case ({b[0], b[1], b[2]})
        3'b001:  code = 3'd0;
        3'b000:  code = 3'd1;
        3'b010:  code = 3'd2;
        3'b011:  code = 3'd3;
        3'b111:  code = 3'd4;
        3'b110:  code = 3'd5;
        3'b100:  code = 3'd6;
        default: code = 3'd7;
      endcase
    end else begin
      case ({b[0], b[1]})
        2'b00:   code = 3'd0;
        2'b01:   code = 3'd2;
        2'b11:   code = 3'd4;
        default: code = 3'd6;
      endcase
    end
    return code;
  endfunction

endpackage

// File: rtl/pa_scrambler_gen.sv
module pa_scrambler_gen #(
  parameter int W = 7,
  parameter int TAP_A = 6,
  parameter int TAP_B = 7,
  parameter logic [W-1:0] SEED = 7'b0111100,
  parameter int MAXS = 3,
  localparam int SW = $clog2(MAXS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            adv,
  input  logic [SW-1:0]   nsteps,
  output logic [MAXS-1:0] bits_o
);

  // st_q[k-1] holds the bit generated k steps ago
  logic [W-1:0] st_q;
  logic [W-1:0] after [MAXS+1];

  always_comb begin
    logic [W-1:0] cur;
    cur = st_q;
    after[0] = st_q;
    for (int i = 0; i < MAXS; i++) begin
      bits_o[i] = 1'b1 ^ cur[TAP_A-1] ^ cur[TAP_B-1];
      cur = {cur[W-2:0], bits_o[i]};
      after[i+1] = cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) st_q <= SEED;
    else if (adv)    st_q <= after[nsteps];
  end

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    st_q != {W{1'b1}}); // R6

endmodule

// File: rtl/pa_seg_ctrl.sv
module pa_seg_ctrl import preamble_pkg::*; #(
  parameter int CARR_LEN  = 300,
  parameter int QUIET_LEN = 32,
  parameter int REV_SHORT = 14,
  parameter int REV_LONG  = 50,
  parameter int EQ_SHORT  = 58,
  parameter int EQ_LONG   = 1074,
  parameter int SYNC_LEN  = 8,
  parameter int OFF_LEN   = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      stb,
  input  logic      rts,
  input  logic      conn,
  input  logic      rate_in,
  input  logic      alt_in,
  output pa_state_e state_q,
  output pa_state_e state_nx,
  output logic      rate_q,
  output logic      alt_q
);

  localparam int TOT = CARR_LEN + QUIET_LEN + REV_LONG + EQ_LONG + SYNC_LEN + OFF_LEN;
  localparam int CW  = $clog2(TOT + 1);

  logic [CW-1:0] cnt_q, cnt_nx, seg_len;
  logic long_q, long_due, conn_q, conn_rise, go, last, start;

  assign conn_rise = conn && !conn_q;
  assign go        = rts && conn;
  assign last      = (cnt_q == seg_len - 1'b1);
  assign start     = (state_nx == ST_CARR) && (state_q != ST_CARR);

  always_comb begin
    case (state_q)
      ST_CARR:  seg_len = CW'(CARR_LEN);
      ST_QUIET: seg_len = CW'(QUIET_LEN);
      ST_REV:   seg_len = long_q ? CW'(REV_LONG) : CW'(REV_SHORT);
      ST_EQ:    seg_len = long_q ? CW'(EQ_LONG) : CW'(EQ_SHORT);
      ST_SYNC:  seg_len = CW'(SYNC_LEN);
      ST_OFF:   seg_len = CW'(OFF_LEN);
      default:  seg_len = CW'(1);
    endcase
  end

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    if (stb) begin
      cnt_nx = cnt_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          cnt_nx = '0;
          if (go) state_nx = ST_CARR;
        end
        ST_DATA: begin
          cnt_nx = '0;
          if (!rts) state_nx = ST_OFF;
        end
        ST_OFF: begin
          if (last) begin
            cnt_nx   = '0;
            state_nx = go ? ST_CARR : ST_IDLE;
          end
        end
        default: begin
          if (!rts) begin
            cnt_nx   = '0;
            state_nx = ST_OFF;
          end else if (last) begin
            cnt_nx   = '0;
            state_nx = pa_state_e'(state_q + 3'd1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      conn_q   <= 1'b0;
      long_due <= 1'b0;
      long_q   <= 1'b0;
      rate_q   <= 1'b0;
      alt_q    <= 1'b0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      conn_q  <= conn;
      if (start) begin
        long_q   <= long_due || conn_rise;
        rate_q   <= rate_in;
        alt_q    <= alt_in;
        long_due <= 1'b0;
      end else if (conn_rise) begin
        long_due <= 1'b1;
      end
    end
  end

  AST_CNT_IN_SEG: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && state_q != ST_DATA) |-> cnt_q < seg_len); // R5

  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CARR && $past(state_q) != ST_CARR) |-> $past(rts && conn && stb)); // R2

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && cnt_q != CW'(OFF_LEN - 1)) |=> state_q != ST_CARR); // R11

endmodule

// File: rtl/preamble_sequencer.sv
module preamble_sequencer import preamble_pkg::*; #(
  parameter int CARR_LEN  = 300,
  parameter int QUIET_LEN = 32,
  parameter int REV_SHORT = 14,
  parameter int REV_LONG  = 50,
  parameter int EQ_SHORT  = 58,
  parameter int EQ_LONG   = 1074,
  parameter int SYNC_LEN  = 8,
  parameter int OFF_LEN   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_stb,
  input  logic       rts_i,
  input  logic       conn_i,
  input  logic       rate_hi_i,
  input  logic       alt_pat_i,
  output logic [2:0] phase_o,
  output logic       carrier_o,
  output logic       rfs_o
);

  localparam int MAXS = 3;
  localparam int SW   = $clog2(MAXS + 1);

  pa_state_e st_q, st_nx;
  logic rate_q, alt_q, adv, load;
  logic [SW-1:0]   nsteps;
  logic [MAXS-1:0] gbits;

  pa_seg_ctrl #(
    .CARR_LEN(CARR_LEN), .QUIET_LEN(QUIET_LEN),
    .REV_SHORT(REV_SHORT), .REV_LONG(REV_LONG),
    .EQ_SHORT(EQ_SHORT), .EQ_LONG(EQ_LONG),
    .SYNC_LEN(SYNC_LEN), .OFF_LEN(OFF_LEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .stb(sym_stb), .rts(rts_i), .conn(conn_i),
    .rate_in(rate_hi_i), .alt_in(alt_pat_i),
    .state_q(st_q), .state_nx(st_nx), .rate_q(rate_q), .alt_q(alt_q)
  );

  always_comb begin
    adv    = sym_stb && (st_nx == ST_EQ || st_nx == ST_SYNC);
    load   = sym_stb && !adv;
    if (st_nx == ST_EQ) nsteps = alt_q ? SW'(2) : SW'(3);
    else                nsteps = rate_q ? SW'(3) : SW'(2);
  end

  pa_scrambler_gen #(.MAXS(MAXS)) u_gen (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .nsteps(nsteps), .bits_o(gbits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o   <= '0;
      carrier_o <= 1'b0;
      rfs_o     <= 1'b0;
    end else if (sym_stb) begin
      phase_o   <= '0;
      carrier_o <= 1'b1;
      rfs_o     <= 1'b0;
      case (st_nx)
        ST_IDLE, ST_QUIET: carrier_o <= 1'b0;
        ST_REV:  phase_o <= 3'd4;
        ST_EQ:   phase_o <= gbits[0] ? 3'd4 : 3'd0;
        ST_SYNC: phase_o <= map_bits(rate_q, gbits);
        ST_DATA: rfs_o   <= 1'b1;
        default: ;
      endcase
    end
  end

  AST_REV_PHASE: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_REV |-> (phase_o == 3'd4 && carrier_o)); // R5

  AST_EQ_BINARY: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_EQ |-> phase_o[1:0] == 2'b00); // R6

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_QUIET |-> !carrier_o); // R4

  AST_RFS_NEEDS_RTS: assert property (@(posedge clk) disable iff (rst)
    $rose(rfs_o) |-> $past(rts_i)); // R9

  AST_RFS_CARRIER: assert property (@(posedge clk) disable iff (rst)
    rfs_o |-> carrier_o); // R9

endmodule

// File: tb/sim_preamble_sequencer.sv
`timescale 1ns/1ps
module sim_preamble_sequencer;

  localparam int CARR = 5;
  localparam int QUIET = 3;
  localparam int OFFL = 6;

  logic clk = 1'b0;
  logic rst, sym_stb, rts_i, conn_i, rate_hi_i, alt_pat_i;
  logic [2:0] phase_o;
  logic carrier_o, rfs_o;

  int checks = 0;
  int failures = 0;
  logic [7:1] bs;

  always #2.5 clk = ~clk;

  preamble_sequencer #(.CARR_LEN(CARR), .QUIET_LEN(QUIET), .OFF_LEN(OFFL)) u0 (
    .clk(clk), .rst(rst), .sym_stb(sym_stb), .rts_i(rts_i), .conn_i(conn_i),
    .rate_hi_i(rate_hi_i), .alt_pat_i(alt_pat_i),
    .phase_o(phase_o), .carrier_o(carrier_o), .rfs_o(rfs_o)
  );

  function automatic logic nb();
    logic b;
    b  = 1'b1 ^ bs[6] ^ bs[7];
    bs = {bs[6:1], b};
    return b;
  endfunction

  function automatic logic [2:0] enc(input logic hi, input logic a, input logic b, input logic c);
    if (hi) begin
      case ({a, b, c})
        3'b001: return 3'd0;  3'b000: return 3'd1;
        3'b010: return 3'd2;  3'b011: return 3'd3;
        3'b111: return 3'd4;  3'b110: return 3'd5;
        3'b100: return 3'd6;  default: return 3'd7;
      endcase
    end
    case ({a, b})
      2'b00: return 3'd0;  2'b01: return 3'd2;
      2'b11: return 3'd4;  default: return 3'd6;
    endcase
  endfunction

  task automatic sym();
    repeat (2) @(negedge clk);
    sym_stb = 1'b1;
    @(negedge clk);
    sym_stb = 1'b0;
  endtask

  task automatic chk(input string req, input logic ec, input logic [2:0] ep, input logic er);
    checks++;
    if (carrier_o !== ec || phase_o !== ep || rfs_o !== er) begin
      failures++;
      $display("FAIL %s: carrier=%0b phase=%0d rfs=%0b expected carrier=%0b phase=%0d rfs=%0b",
               req, carrier_o, phase_o, rfs_o, ec, ep, er);
    end
  endtask

  task automatic run_pre(input bit lng, input bit alt, input bit hi, input int abort_at, input int ndata);
    int lens [6];
    int k = 0;
    logic a, b, c;
    lens[0] = CARR; lens[1] = QUIET; lens[2] = lng ? 50 : 14;
    lens[3] = lng ? 1074 : 58; lens[4] = 8; lens[5] = ndata;
    bs = 7'b0111100;
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < lens[s]; i++) begin
        if (k == abort_at) begin
          rts_i = 1'b0;
          return;
        end
        sym();
        case (s)
          0: chk("R4 carrier R3", 1'b1, 3'd0, 1'b0);
          1: chk("R4 quiet", 1'b0, 3'd0, 1'b0);
          2: chk("R5 reversals R3", 1'b1, 3'd4, 1'b0);
          3: begin
            a = nb();
            for (int j = 1; j < (alt ? 2 : 3); j++) b = nb();
            chk(alt ? "R7 alt pattern R12" : "R6 pattern R12", 1'b1, a ? 3'd4 : 3'd0, 1'b0);
          end
          4: begin
            a = nb(); b = nb(); c = hi ? nb() : 1'b0;
            chk("R8 sync R12", 1'b1, enc(hi, a, b, c), 1'b0);
          end
          default: chk("R9 ready", 1'b1, 3'd0, 1'b1);
        endcase
        if (k == 0) begin // R12: mode inputs change after start
          alt_pat_i = ~alt_pat_i;
          rate_hi_i = ~rate_hi_i;
        end
        k++;
      end
    end
  endtask

  task automatic run_off(input int raise_at);
    for (int i = 0; i < OFFL; i++) begin
      if (i == raise_at) rts_i = 1'b1;
      sym();
      chk(raise_at >= 0 ? "R11 deferred" : "R10 turn-off", 1'b1, 3'd0, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1: watchdog expired, actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; sym_stb = 1'b0; rts_i = 1'b0; conn_i = 1'b0;
    rate_hi_i = 1'b1; alt_pat_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 reset", 1'b0, 3'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 1'b0, 3'd0, 1'b0);

    // R2: request without connection does nothing
    rts_i = 1'b1;
    repeat (3) begin sym(); chk("R2 no conn", 1'b0, 3'd0, 1'b0); end

    // R3: connection rises with request already on -> long, default pattern, high rate
    conn_i = 1'b1;
    run_pre(1'b1, 1'b0, 1'b1, -1, 4);

    // R10 turn-off, R11 request raised inside it, then short at low rate, alt mode
    rts_i = 1'b0; alt_pat_i = 1'b1; rate_hi_i = 1'b0;
    run_off(2);
    run_pre(1'b0, 1'b1, 1'b0, -1, 3);

    // R10: drop then idle
    rts_i = 1'b0;
    run_off(-1);
    repeat (2) begin sym(); chk("R10 idle", 1'b0, 3'd0, 1'b0); end

    // R10: abort in the middle of segment four
    alt_pat_i = 1'b0; rate_hi_i = 1'b1; rts_i = 1'b1;
    run_pre(1'b0, 1'b0, 1'b1, CARR + QUIET + 14 + 10, 0);
    run_off(-1);
    sym(); chk("R10 idle after abort", 1'b0, 3'd0, 1'b0);

    // R2 and R3: connection drop, request on, reconnect -> long again
    conn_i = 1'b0; rts_i = 1'b1;
    repeat (2) begin sym(); chk("R2 conn low", 1'b0, 3'd0, 1'b0); end
    alt_pat_i = 1'b1; rate_hi_i = 1'b1;
    conn_i = 1'b1;
    run_pre(1'b1, 1'b1, 1'b1, -1, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule